// File: doc/BRIEF.md
# Multiplierless Transposed-Form FIR Filter

This block is a fully parallel FIR filter whose coefficients are fixed when the design is built. It has no general multipliers. Every accepted input sample goes to all taps in the same cycle. Each tap scales the sample by its constant coefficient with a chain of shifted additions, one adder for each set magnitude bit of that coefficient. A coefficient bit that is zero produces no logic. The scaled values then run through a transposed accumulation chain. A register sits between each pair of adders, so glitches do not ripple along the whole sum.

Coefficients are given as signed fixed-point fractions in the range [-1, 1) at a source width, and are reduced to a smaller configured width by keeping the most significant bits. Two sets of parameters come from the system designer:

- the tap count and the coefficient width;
- the coefficient values themselves.

The block also reports a constant count of the coefficient one bits. This count is the figure that sets the adder cost, so the designer can compare candidate configurations by it.

The output is the full-precision sum, `DW + CW + clog2(NTAPS)` bits wide. If the input has F fraction bits, the output has F + CW - 1 fraction bits.

Top module: `fir_shiftadd_tf`

## Requirements
- R1: When `in_valid` is high at a rising edge, the output produced is `sum over i = 0..NTAPS-1 of c[i] * x[n-i]`, bit-exact, where x[n] is the sample just accepted and x[n-i] is the sample accepted i acceptances earlier. Samples from before the last reset count as zero.
- R2: `out_valid` is high in the cycle after each edge where `in_valid` is high and `rst` is low, and it is low after every other edge. The latency is exactly one cycle.
- R3: The accumulation is wide enough that the output never wraps. This includes inputs at full scale, -2^(DW-1) or 2^(DW-1)-1, aligned with the coefficient signs on every tap at once.
- R4: An edge with `in_valid` low does not advance the delay chain, and `din` is ignored on such an edge. `dout` holds its value, and the next accepted sample continues the sequence as if there had been no gap.
- R5: A synchronous `rst` clears every delay register and the output register. After reset, `dout` is 0 and `out_valid` is 0, and no sample accepted before the reset contributes to later outputs.
- R6: Tap i is taken from bits [i*SRC_W +: SRC_W] of `COEFS` as a signed two's-complement value. It is truncated to c[i] = floor(raw / 2^(SRC_W-CW)), which means the top CW bits are kept.
- R7: Negative coefficients, including the full-scale value -2^(CW-1), scale samples exactly: the product is the negated sum of the shifted magnitude terms.
- R8: `ones_total` is constant and equals the sum over all taps of the number of one bits in |c[i]|, where |c[i]| is read as an unsigned CW-bit magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on `din` is accepted at this edge |
| din | input | DW | Signed input sample |
| out_valid | output | 1 | `dout` holds a new filtered sample |
| dout | output | DW+CW+clog2(NTAPS) | Signed full-precision filter output |
| ones_total | output | clog2(NTAPS*CW+1) | Total set magnitude bits across all truncated coefficients |

## Verification
The hardest state to reach from the ports is the worst-case accumulation. Every one of the 37 taps must see a full-scale sample whose sign matches its coefficient, all in the same output cycle. That is the only case where a narrow accumulator would wrap. The bench reaches it by streaming 37 consecutive samples, with the j-th chosen from the sign of coefficient NTAPS-1-j. It then repeats the stream with every sign reversed to reach the negative extreme. The coefficient set also contains the exact -1 value, a zero coefficient and the largest positive value. Idle cycles carry random data on `din` to show that the data is ignored. A reset in mid-stream is followed by an impulse, to show that older history is gone.

// File: rtl/fir_sa_pkg.sv
`timescale 1ns/1ps
package fir_sa_pkg;

   // Sign-extend a raw source-width coefficient and keep its top cw bits.
   function automatic int trunc_coef(logic [31:0] raw, int srcw, int cw);
      longint v;
      v = longint'(raw & ((64'd1 << srcw) - 64'd1));
      if (raw[srcw-1]) v = v - (longint'(1) << srcw);
      return int'(v >>> (srcw - cw));
   endfunction

   // Magnitude of a truncated coefficient.
   function automatic int coef_mag(int c);
      return (c < 0) ? -c : c;
   endfunction

   // Number of set bits in the low cw bits of a value.
   function automatic int ones_in(int v, int cw);
      int n;
      n = 0;
      for (int b = 0; b < cw; b++) n += (v >> b) & 1;
      return n;
   endfunction

endpackage

// File: rtl/fir_sa_term.sv
`timescale 1ns/1ps
// Constant-coefficient scaler built from shifted additions only.
module fir_sa_term #(
   parameter int DW   = 12,
   parameter int CW   = 10,
   parameter int PW   = 26,
   parameter int COEF = 0
) (
   input  logic signed [DW-1:0] x,
   output logic signed [PW-1:0] p
);
   localparam bit          NEG  = (COEF < 0);
   localparam int          MAG  = fir_sa_pkg::coef_mag(COEF);
   localparam logic [CW:0] MAGV = MAG[CW:0];

   logic signed [PW-1:0] xe;
   logic signed [PW-1:0] acc [CW+1];

   assign xe     = {{(PW-DW){x[DW-1]}}, x};
   assign acc[0] = '0;

   for (genvar b = 0; b < CW; b++) begin : g_bit
      if (MAGV[b]) begin : g_add
         assign acc[b+1] = acc[b] + (xe <<< b);
      end else begin : g_pass
         assign acc[b+1] = acc[b];
      end
   end

   if (NEG) begin : g_neg
      assign p = -acc[CW];
   end else begin : g_pos
      assign p = acc[CW];
   end
endmodule

// File: rtl/fir_shiftadd_tf.sv
`timescale 1ns/1ps
module fir_shiftadd_tf #(
   parameter int NTAPS = 8,
   parameter int DW    = 12,
   parameter int SRC_W = 16,
   parameter int CW    = 10,
   parameter logic [NTAPS*SRC_W-1:0] COEFS = {
      16'hFC40, 16'h0610, 16'h1A2B, 16'h3F01,
      16'h3F01, 16'h1A2B, 16'h0610, 16'hFC40},
   localparam int AW = DW + CW + $clog2(NTAPS),
   localparam int OW = $clog2(NTAPS*CW + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] din,
   output logic                 out_valid,
   output logic signed [AW-1:0] dout,
   output logic [OW-1:0]        ones_total
);
   // Elaboration-time parameter checks.
   if (NTAPS < 2 || NTAPS > 256) begin : g_bad_taps
      $error("fir_shiftadd_tf: NTAPS out of range");
   end
   if (SRC_W < 2 || SRC_W > 32) begin : g_bad_src
      $error("fir_shiftadd_tf: SRC_W out of range");
   end
   if (CW < 2 || CW > SRC_W) begin : g_bad_cw
      $error("fir_shiftadd_tf: CW must lie in 2..SRC_W");
   end
   if (DW < 2) begin : g_bad_dw
      $error("fir_shiftadd_tf: DW too small");
   end

   function automatic int count_ones();
      int t;
      t = 0;
      for (int k = 0; k < NTAPS; k++)
         t += fir_sa_pkg::ones_in(fir_sa_pkg::coef_mag(
                 fir_sa_pkg::trunc_coef(32'(COEFS[k*SRC_W +: SRC_W]), SRC_W, CW)), CW + 1);
      return t;
   endfunction

   localparam int ONES = count_ones();
   assign ones_total = OW'(ONES);

   logic signed [AW-1:0] prod [NTAPS];
   logic signed [AW-1:0] stage [NTAPS];

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam int CK =
         fir_sa_pkg::trunc_coef(32'(COEFS[k*SRC_W +: SRC_W]), SRC_W, CW);

      fir_sa_term #(.DW(DW), .CW(CW), .PW(AW), .COEF(CK)) u_term (
         .x (din),
         .p (prod[k])
      );

      if (k == NTAPS - 1) begin : g_tail
         always_ff @(posedge clk) begin
            if (rst)           stage[k] <= '0;
            else if (in_valid) stage[k] <= prod[k];
         end
      end else begin : g_link
         always_ff @(posedge clk) begin
            if (rst)           stage[k] <= '0;
            else if (in_valid) stage[k] <= prod[k] + stage[k+1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   assign dout = stage[0];
endmodule

// File: rtl/fir_sa_chk.sv
`timescale 1ns/1ps
module fir_sa_chk #(
   parameter int DW = 12,
   parameter int AW = 26
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic signed [DW-1:0] din,
   input logic                 out_valid,
   input logic signed [AW-1:0] dout
);
   logic zero_hist;
   logic rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                        zero_hist <= 1'b1;
      else if (in_valid && din != '0) zero_hist <= 1'b0;
   end

   p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_idle_valid_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(dout));

   p_zero_hist_r1: assert property (@(posedge clk) disable iff (rst)
      zero_hist |-> dout == '0);

   always @(posedge clk) begin
      if (rst_q == 1'b1) begin
         p_reset_clears_r5: assert (!out_valid && dout == '0);
      end
   end
endmodule

bind fir_shiftadd_tf fir_sa_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .din(din),
   .out_valid(out_valid), .dout(dout)
);

// File: tb/fir_shiftadd_tf_tb.sv
`timescale 1ns/1ps
module fir_shiftadd_tf_tb;
   localparam int NT = 37;
   localparam int DW = 12;
   localparam int SW = 16;
   localparam int CW = 11;
   localparam int AW = DW + CW + $clog2(NT);
   localparam int OW = $clog2(NT*CW + 1);

   function automatic int src_val(int i);
      int v;
      v = ((i * 7919 + 331) % 60000) - 30000;
      if (i == 5)  v = -32768;
      if (i == 11) v = 0;
      if (i == 20) v = 32767;
      return v;
   endfunction

   function automatic logic [NT*SW-1:0] build();
      logic [NT*SW-1:0] r;
      r = '0;
      for (int i = 0; i < NT; i++) r[i*SW +: SW] = 16'(src_val(i));
      return r;
   endfunction

   localparam logic [NT*SW-1:0] COEFS_TB = build();

   logic clk = 0, rst = 1, vin = 0;
   logic signed [DW-1:0] din = '0;
   logic out_valid;
   logic signed [AW-1:0] dout;
   logic [OW-1:0] ones_total;

   fir_shiftadd_tf #(.NTAPS(NT), .DW(DW), .SRC_W(SW), .CW(CW), .COEFS(COEFS_TB)) u_dut (
      .clk(clk), .rst(rst), .in_valid(vin), .din(din),
      .out_valid(out_valid), .dout(dout), .ones_total(ones_total)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int coef [NT];
   longint hist [NT];
   longint exp_q[$];
   string  tag_q[$];
   longint prev_dout = 0;
   bit done = 0;

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send(int x, string tag);
      longint s;
      @(negedge clk);
      vin = 1; din = DW'(x);
      for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      s = 0;
      for (int i = 0; i < NT; i++) s += longint'(coef[i]) * hist[i];
      exp_q.push_back(s);
      tag_q.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         vin = 0;
         din = DW'($urandom);
      end
   endtask

   task automatic do_reset(int n);
      @(negedge clk);
      rst = 1; vin = 0;
      repeat (n) @(negedge clk);
      rst = 0;
      for (int i = 0; i < NT; i++) hist[i] = 0;
      exp_q.delete(); tag_q.delete();
      check(!out_valid && dout == 0, "R5 reset state", longint'(dout), 0);
   endtask

   // Monitor / scoreboard.
   initial forever begin
      @(posedge clk);
      #2;
      check(out_valid == (vin && !rst), "R2 valid latency", longint'(out_valid),
            longint'(vin && !rst));
      if (!rst) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(0, "R1 unexpected output", longint'(dout), 0);
            end else begin
               longint e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(longint'(dout) == e, t, longint'(dout), e);
            end
         end else begin
            check(longint'(dout) == prev_dout, "R4 hold while idle", longint'(dout), prev_dout);
         end
      end
      prev_dout = longint'(dout);
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int ones;
      ones = 0;
      for (int i = 0; i < NT; i++) begin
         coef[i] = src_val(i) >>> (SW - CW);   // R6: keep top CW bits
         ones += $countones((coef[i] < 0) ? -coef[i] : coef[i]);
         hist[i] = 0;
      end
      repeat (3) @(negedge clk);
      do_reset(1);
      check(int'(ones_total) == ones, "R8 ones count", longint'(ones_total), ones);
      // R6: impulse exposes each truncated coefficient
      send(1, "R6 impulse");
      for (int k = 0; k < NT + 2; k++) send(0, "R6 impulse tail");
      idle(3);
      // R7: negative full-scale impulse
      send(-2048, "R7 negative impulse");
      for (int k = 0; k < NT; k++) send(0, "R7 impulse tail");
      idle(2);
      // R1: random stream
      for (int k = 0; k < 200; k++) send(int'($urandom_range(4095)) - 2048, "R1 random");
      idle(2);
      // R4: random stream with idle gaps carrying garbage data
      for (int k = 0; k < 120; k++) begin
         send(int'($urandom_range(4095)) - 2048, "R4 gapped");
         if ((k % 3) == 1) idle(1 + (k % 4));
      end
      idle(3);
      // R3: full-scale positive then negative extremes
      for (int j = 0; j < NT; j++) send(coef[NT-1-j] >= 0 ? 2047 : -2048, "R3 max sum");
      for (int j = 0; j < NT; j++) send(coef[NT-1-j] >= 0 ? -2048 : 2047, "R3 min sum");
      idle(3);
      // R5: mid-stream reset, then impulse sees no old history
      for (int k = 0; k < 10; k++) send(1500 - k * 300, "R5 before reset");
      do_reset(2);
      send(3, "R5 impulse after reset");
      for (int k = 0; k < NT; k++) send(0, "R5 tail after reset");
      idle(4);
      check(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule